// File: doc/BRIEF.md
# External Memory Bank Select Controller

This block sits in front of an external asynchronous memory interface and owns its configuration. A small register bus reaches three registers: a 16-bit global control word and two 32-bit bank timing/configuration words. Each access carries a size qualifier. The block checks every access, answers it one cycle later with read data or an error pulse, and reports whether an error came from the access width or from an unmapped offset.

In parallel it decodes an external-memory address into one of four equal bank windows above a base address. The bank size is a parameter, normally 1 MiB or 64 MiB. A bank produces a chip select only while the global control word enables it. An enabled bank claims its window whether or not a device answers there.

A small response state machine sequences the register side. RSP_IDLE is the state with no response pending. An accepted legal access moves to RSP_DONE and an accepted illegal one moves to RSP_FAULT, each for one cycle. From any state the machine returns to RSP_IDLE when no access is offered, and goes to RSP_DONE or RSP_FAULT again when a new access is accepted.

Top module: `xmem_bank_ctl`

## Requirements
- R1: Offset 0x0 selects the global control word, 0x4 selects bank word A and 0x8 selects bank word B. Every other offset, including misaligned ones, is unmapped and an access to it ends in an error with `reg_err_width` low.
- R2: `reg_size` encodes 0 = 8-bit, 1 = 16-bit, 2 = 32-bit and 3 = reserved. A size other than 16 or 32 bits is a width error (`reg_err` and `reg_err_width` both high) at every offset, mapped or not.
- R3: The global control word accepts only 16-bit accesses. A 32-bit access to it is a width error and leaves it unchanged. A 16-bit write stores `reg_wdata[15:0]`, and a read returns it zero-extended.
- R4: The bank words accept only 32-bit accesses. A 16-bit access to them is a width error and leaves them unchanged.
- R5: After reset the global control word is 0 and both bank words are 0xFFC2FFC2, or 0x0000FFC2 when `NARROW_RST` is 1.
- R6: The number of enabled banks is global control bits [3:1], saturated at 4. Banks 0 up to that count minus one are enabled, and the other control bits have no effect on decoding.
- R7: Bank i spans `REGION_BASE + i*2^BANK_SHIFT` up to one byte below the next bank. Addresses below `REGION_BASE`, or at or above `REGION_BASE + 4*2^BANK_SHIFT`, select no bank.
- R8: `bank_cs` is one-hot for an address in an enabled bank and zero otherwise. `bank_hit` equals "some bank selected". Both follow `mem_addr` combinationally in the same cycle.
- R9: A write to the global control word changes decoding from the first cycle after the accepting edge, with no further sequence.
- R10: The response to an access is shown for exactly one cycle after the accepting edge. On an error `reg_rdata` is 0. With no access accepted, `reg_err` is low and `reg_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access offered and accepted this cycle |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_offset | input | OFF_W | Byte offset of the register |
| reg_size | input | 2 | Access size code |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after acceptance |
| reg_err | output | 1 | Error pulse, the cycle after acceptance |
| reg_err_width | output | 1 | With reg_err: 1 = width error, 0 = unmapped offset |
| mem_addr | input | ADDR_W | External-memory address to decode |
| bank_cs | output | 4 | One-hot bank chip selects |
| bank_hit | output | 1 | Address claimed by an enabled bank |

## Verification
The clocked properties assume that `reg_valid`, `reg_write`, `reg_size` and `reg_offset` are stable at each rising edge and that `reg_valid` is low during reset. The bench therefore changes every input on the falling edge and holds `reg_valid` low until reset is released. The decode properties assume only that `mem_addr` is a defined value. The bench sweeps it across every bank edge, below the region and past its top, for all eight values of the bank-count field.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int NUM_BANKS = 4;
    localparam int GCTL_W    = 16;
    localparam int BCTL_W    = 32;
    localparam int CNT_W     = 3;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } xfer_size_e;

    typedef enum logic [1:0] {
        CLS_OK       = 2'd0,
        CLS_WIDTH    = 2'd1,
        CLS_UNMAPPED = 2'd2
    } acc_class_e;

    typedef enum logic [1:0] {
        SEL_GLOBAL = 2'd0,
        SEL_BANKA  = 2'd1,
        SEL_BANKB  = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DONE  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

    function automatic logic [CNT_W-1:0] clamp_count(input logic [CNT_W-1:0] raw);
        return (raw > CNT_W'(NUM_BANKS)) ? CNT_W'(NUM_BANKS) : raw;
    endfunction

endpackage

// File: rtl/xmem_acc_chk.sv
module xmem_acc_chk
    import xmem_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic [OFF_W-1:0] offset,
    input  logic [1:0]       size,
    output reg_sel_e         sel,
    output acc_class_e       cls
);

    localparam logic [OFF_W-1:0] OFF_GLOBAL = OFF_W'(0);
    localparam logic [OFF_W-1:0] OFF_BANKA  = OFF_W'(4);
    localparam logic [OFF_W-1:0] OFF_BANKB  = OFF_W'(8);

    logic size_legal;

    always_comb begin
        if (offset == OFF_GLOBAL)      sel = SEL_GLOBAL;
        else if (offset == OFF_BANKA)  sel = SEL_BANKA;
        else if (offset == OFF_BANKB)  sel = SEL_BANKB;
        else                           sel = SEL_NONE;
    end

    assign size_legal = (size == SZ_HALF) || (size == SZ_WORD);

    // width legality is tested before the offset decode
    always_comb begin
        if (!size_legal)                             cls = CLS_WIDTH;
        else if (sel == SEL_NONE)                    cls = CLS_UNMAPPED;
        else if (sel == SEL_GLOBAL && size != SZ_HALF) cls = CLS_WIDTH;
        else if (sel != SEL_GLOBAL && size != SZ_WORD) cls = CLS_WIDTH;
        else                                         cls = CLS_OK;
    end

endmodule

// File: rtl/xmem_reg_file.sv
module xmem_reg_file
    import xmem_pkg::*;
#(
    parameter logic [BCTL_W-1:0] BCTL_RST = 32'hFFC2FFC2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [1:0]        acc_size,
    input  logic [31:0]       acc_wdata,
    input  reg_sel_e          sel,
    input  acc_class_e        cls,
    output logic [CNT_W-1:0]  count_field,
    output logic [31:0]       rdata,
    output logic              err,
    output logic              err_width
);

    rsp_state_e          state_q, state_d;
    logic [GCTL_W-1:0]   gctl_q;
    logic [BCTL_W-1:0]   bctla_q, bctlb_q;
    logic [31:0]         rd_mux, rd_q;
    logic                werr_q;
    logic                wr_ok;

    assign wr_ok       = acc_valid && acc_write && (cls == CLS_OK);
    assign count_field = gctl_q[CNT_W:1];

    // next-state logic
    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_DONE, RSP_FAULT: begin
                if (acc_valid) state_d = (cls == CLS_OK) ? RSP_DONE : RSP_FAULT;
                else           state_d = RSP_IDLE;
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RSP_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        unique case (sel)
            SEL_GLOBAL: rd_mux = {{(32-GCTL_W){1'b0}}, gctl_q};
            SEL_BANKA:  rd_mux = bctla_q;
            SEL_BANKB:  rd_mux = bctlb_q;
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gctl_q  <= '0;
            bctla_q <= BCTL_RST;
            bctlb_q <= BCTL_RST;
            rd_q    <= '0;
            werr_q  <= 1'b0;
        end else begin
            if (wr_ok) begin
                unique case (sel)
                    SEL_GLOBAL: gctl_q  <= acc_wdata[GCTL_W-1:0];
                    SEL_BANKA:  bctla_q <= acc_wdata;
                    SEL_BANKB:  bctlb_q <= acc_wdata;
                    default:    ;
                endcase
            end
            rd_q   <= (acc_valid && !acc_write && cls == CLS_OK) ? rd_mux : '0;
            werr_q <= (cls == CLS_WIDTH);
        end
    end

    // output logic
    always_comb begin
        rdata     = '0;
        err       = 1'b0;
        err_width = 1'b0;
        unique case (state_q)
            RSP_IDLE:  ;
            RSP_DONE:  rdata = rd_q;
            RSP_FAULT: begin
                err       = 1'b1;
                err_width = werr_q;
            end
            default:   ;
        endcase
    end

    // R3
    // R4
    reject_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && cls != CLS_OK) |=>
            ($stable(gctl_q) && $stable(bctla_q) && $stable(bctlb_q)));

    // R2
    width_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && (acc_size == SZ_BYTE || acc_size == SZ_RSVD)) |=> (err && err_width));

    // R3
    gctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && sel == SEL_GLOBAL && cls == CLS_OK) |=>
            (gctl_q == $past(acc_wdata[GCTL_W-1:0])));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!err && rdata == '0));

endmodule

// File: rtl/xmem_bank_dec.sv
module xmem_bank_dec
    import xmem_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                BANK_SHIFT  = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    mem_addr,
    input  logic [CNT_W-1:0]     count_field,
    output logic [NUM_BANKS-1:0] bank_cs,
    output logic                 bank_hit
);

    localparam int IDX_W       = $clog2(NUM_BANKS);
    localparam int REGION_BITS = BANK_SHIFT + IDX_W;
    localparam logic [ADDR_W-1:0] REGION_SPAN = ADDR_W'(1) << REGION_BITS;

    logic [ADDR_W-1:0] rel_addr;
    logic              in_region;
    logic [IDX_W-1:0]  bank_idx;
    logic [CNT_W-1:0]  bank_count;

    assign rel_addr   = mem_addr - REGION_BASE;
    assign in_region  = (mem_addr >= REGION_BASE) &&
                        (rel_addr[ADDR_W-1:REGION_BITS] == '0);
    assign bank_idx   = rel_addr[BANK_SHIFT +: IDX_W];
    assign bank_count = clamp_count(count_field);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        assign bank_cs[i] = in_region && (bank_idx == IDX_W'(i)) &&
                            (CNT_W'(i) < bank_count);

        // R6
        cs_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bank_cs[i] |-> (count_field > CNT_W'(i)));
    end

    assign bank_hit = |bank_cs;

    // R7
    hit_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_hit |-> ((mem_addr - REGION_BASE) < REGION_SPAN && mem_addr >= REGION_BASE));

    // R8
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_cs));

endmodule

// File: rtl/xmem_bank_ctl.sv
module xmem_bank_ctl
    import xmem_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                OFF_W       = 8,
    parameter int                BANK_SHIFT  = 20,
    parameter logic [ADDR_W-1:0] REGION_BASE = 32'h2000_0000,
    parameter bit                NARROW_RST  = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_valid,
    input  logic                 reg_write,
    input  logic [OFF_W-1:0]     reg_offset,
    input  logic [1:0]           reg_size,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 reg_err,
    output logic                 reg_err_width,
    input  logic [ADDR_W-1:0]    mem_addr,
    output logic [NUM_BANKS-1:0] bank_cs,
    output logic                 bank_hit
);

    localparam logic [BCTL_W-1:0] BCTL_RST = NARROW_RST ? 32'h0000_FFC2 : 32'hFFC2_FFC2;

    reg_sel_e         sel;
    acc_class_e       cls;
    logic [CNT_W-1:0] count_field;

    xmem_acc_chk #(.OFF_W(OFF_W)) u_chk (
        .offset (reg_offset),
        .size   (reg_size),
        .sel    (sel),
        .cls    (cls)
    );

    xmem_reg_file #(.BCTL_RST(BCTL_RST)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (reg_valid),
        .acc_write   (reg_write),
        .acc_size    (reg_size),
        .acc_wdata   (reg_wdata),
        .sel         (sel),
        .cls         (cls),
        .count_field (count_field),
        .rdata       (reg_rdata),
        .err         (reg_err),
        .err_width   (reg_err_width)
    );

    xmem_bank_dec #(
        .ADDR_W      (ADDR_W),
        .BANK_SHIFT  (BANK_SHIFT),
        .REGION_BASE (REGION_BASE)
    ) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .mem_addr    (mem_addr),
        .count_field (count_field),
        .bank_cs     (bank_cs),
        .bank_hit    (bank_hit)
    );

endmodule

// File: tb/xmem_bank_ctl_tb.sv
module xmem_bank_ctl_tb_top;

    localparam int          AW    = 32;
    localparam int          SHIFT = 20;
    localparam logic [31:0] BASE  = 32'h2000_0000;
    localparam logic [31:0] BSIZE = 32'h1 << SHIFT;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_valid = 1'b0, reg_write = 1'b0;
    logic [7:0]  reg_offset = '0;
    logic [1:0]  reg_size = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] mem_addr = '0;
    logic [31:0] rdata, rdata_n;
    logic        err, err_w, err_n, err_wn;
    logic [3:0]  cs, cs_n;
    logic        hit, hit_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [15:0] m_gctl;
    logic [31:0] m_ba, m_bb;

    always #5 clk = ~clk;

    xmem_bank_ctl #(.ADDR_W(AW), .OFF_W(8), .BANK_SHIFT(SHIFT), .REGION_BASE(BASE),
                    .NARROW_RST(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_offset(reg_offset), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(rdata), .reg_err(err), .reg_err_width(err_w),
        .mem_addr(mem_addr), .bank_cs(cs), .bank_hit(hit));

    xmem_bank_ctl #(.ADDR_W(AW), .OFF_W(8), .BANK_SHIFT(SHIFT), .REGION_BASE(BASE),
                    .NARROW_RST(1'b1)) dut_n (
        .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
        .reg_offset(reg_offset), .reg_size(reg_size), .reg_wdata(reg_wdata),
        .reg_rdata(rdata_n), .reg_err(err_n), .reg_err_width(err_wn),
        .mem_addr(mem_addr), .bank_cs(cs_n), .bank_hit(hit_n));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // 0 = legal, 1 = width error, 2 = unmapped
    function automatic int exp_class(input int off, input int sz);
        if (sz != 1 && sz != 2)           return 1;
        if (off != 0 && off != 4 && off != 8) return 2;
        if (off == 0 && sz != 1)          return 1;
        if (off != 0 && sz != 2)          return 1;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(input int off);
        if (off == 0) return {16'h0, m_gctl};
        if (off == 4) return m_ba;
        return m_bb;
    endfunction

    task automatic access(input bit wr, input int off, input int sz, input logic [31:0] d,
                          output logic [31:0] rd, output logic e, output logic ew);
        @(negedge clk);
        reg_valid  = 1'b1;
        reg_write  = wr;
        reg_offset = off[7:0];
        reg_size   = sz[1:0];
        reg_wdata  = d;
        @(negedge clk);
        reg_valid  = 1'b0;
        rd = rdata;
        e  = err;
        ew = err_w;
    endtask

    task automatic check_access(input bit wr, input int off, input int sz,
                                input logic [31:0] d, input string req);
        logic [31:0] rd;
        logic e, ew;
        int cl;
        cl = exp_class(off, sz);
        access(wr, off, sz, d, rd, e, ew);
        chk(e == (cl != 0), req, {31'b0, e}, {31'b0, cl != 0});
        if (cl != 0) begin
            chk(ew == (cl == 1), req, {31'b0, ew}, {31'b0, cl == 1});
            chk(rd == 32'h0, {req, " R10 err data"}, rd, 32'h0);
        end else if (!wr) begin
            chk(rd == model_read(off), req, rd, model_read(off));
        end
        if (wr && cl == 0) begin
            if (off == 0) m_gctl = d[15:0];
            else if (off == 4) m_ba = d;
            else m_bb = d;
        end
        // R10: one-cycle response
        @(negedge clk);
        chk(!err && rdata == 32'h0, "R10 pulse width", {31'b0, err}, 32'h0);
    endtask

    task automatic set_count(input int n);
        logic [31:0] rd;
        logic e, ew;
        logic [15:0] v;
        v = 16'hF0F1 | 16'(n << 1);
        v[3:1] = 3'(n);
        access(1'b1, 0, 1, {16'hDEAD, v}, rd, e, ew);
        m_gctl = v;
        chk(!e, "R3 gctl write", {31'b0, e}, 32'h0);
    endtask

    task automatic check_decode(input logic [31:0] a, input int n, input string req);
        logic [3:0] exp;
        int idx;
        int en;
        en = (n > 4) ? 4 : n;
        exp = 4'b0;
        if (a >= BASE && (a - BASE) < 4 * BSIZE) begin
            idx = int'((a - BASE) / BSIZE);
            if (idx < en) exp = 4'(1 << idx);
        end
        @(negedge clk);
        mem_addr = a;
        #1;
        chk(cs == exp, req, {28'b0, cs}, {28'b0, exp});
        chk(hit == (exp != 0), {req, " R8 hit"}, {31'b0, hit}, {31'b0, exp != 0});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        logic e, ew;
        m_gctl = 16'h0;
        m_ba   = 32'hFFC2FFC2;
        m_bb   = 32'hFFC2FFC2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R5: reset values, both variants
        @(negedge clk);
        chk(!err && rdata == 0, "R10 idle after reset", rdata, 32'h0);
        access(1'b0, 0, 1, 0, rd, e, ew);
        chk(rd == 32'h0, "R5 gctl reset", rd, 32'h0);
        access(1'b0, 4, 2, 0, rd, e, ew);
        chk(rd == 32'hFFC2FFC2, "R5 bank A reset", rd, 32'hFFC2FFC2);
        chk(rdata_n == 32'h0000FFC2, "R5 narrow bank A reset", rdata_n, 32'h0000FFC2);
        access(1'b0, 8, 2, 0, rd, e, ew);
        chk(rd == 32'hFFC2FFC2, "R5 bank B reset", rd, 32'hFFC2FFC2);
        chk(rdata_n == 32'h0000FFC2, "R5 narrow bank B reset", rdata_n, 32'h0000FFC2);
        check_decode(BASE, 0, "R6 all banks off after reset");

        // R1 R2 R3 R4: read sweep over offsets and sizes
        for (int off = 0; off < 16; off++)
            for (int sz = 0; sz < 4; sz++)
                check_access(1'b0, off, sz, 32'h0, "R1 R2 R3 R4 read sweep");
        check_access(1'b0, 8'hFC, 2, 32'h0, "R1 high unmapped");
        check_access(1'b0, 8'hFC, 3, 32'h0, "R2 width over unmapped");

        // write sweep; every register read back after each write
        for (int off = 0; off < 12; off++)
            for (int sz = 0; sz < 4; sz++) begin
                check_access(1'b1, off, sz,
                             32'hA5C3_0000 ^ 32'(off << 12) ^ 32'(sz << 4) ^ 32'h0000_1234,
                             "R1 R2 R3 R4 write sweep");
                check_access(1'b0, 0, 1, 0, "R3 gctl readback");
                check_access(1'b0, 4, 2, 0, "R4 bank A readback");
                check_access(1'b0, 8, 2, 0, "R4 bank B readback");
            end

        // R9: decode follows a control write on the next cycle
        set_count(0);
        check_decode(BASE + 32'h10, 0, "R9 before enable");
        set_count(1);
        #1;
        chk(cs == 4'b0001, "R9 after enable", {28'b0, cs}, 32'h1);

        // R6 R7 R8: decode sweep for every count value
        for (int n = 0; n < 8; n++) begin
            set_count(n);
            check_decode(BASE - 32'h1, n, "R7 below region");
            check_decode(BASE + 4 * BSIZE, n, "R7 above region");
            check_decode(32'hFFFF_FFF0, n, "R7 far above");
            for (int b = 0; b < 4; b++) begin
                check_decode(BASE + b * BSIZE, n, "R6 R7 bank start");
                check_decode(BASE + b * BSIZE + BSIZE / 2, n, "R6 bank middle");
                check_decode(BASE + (b + 1) * BSIZE - 1, n, "R7 bank end");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule